// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves 8-bit characters over a three-wire serial link: one data output, one data input and one clock pin that is bidirectional. Bits travel least significant first. The data output changes only after a falling clock edge, and the data input is captured on the rising edge. Between characters the clock rests high. The transmit path and the receive path run side by side on the same clock, so one character goes out while another comes in.

The serial clock has two possible sources. With the internal source, a programmable divider makes the clock and the block drives it onto the pin. Each half period lasts `div_n + 1` system cycles, and each character takes exactly eight pulses. With the external source, the pin is an input. It is synchronized through two flops and its edges are detected in the system clock domain, so it must run at no more than one sixth of the system clock rate.

Both directions are double buffered. On the host side there are two valid/ready streams. The transmit stream takes a byte whenever its one-entry holding buffer is empty. The holding buffer empties when the byte moves into the shifter at the first falling edge of its character. The receive stream presents each completed byte and holds `m_rx_valid` and `m_rx_data` steady until the host accepts it. That back-pressure is not lossless: if a character completes while the previous one is still unread, the new byte is dropped and an overrun is flagged.

Top module: `sync_serial_xcvr`

## Requirements
- R1: A byte accepted on the transmit stream appears on `sd_o` as 8 bits, bit 0 first. Bit k is valid at the (k+1)-th rising edge of the serial clock in that character.
- R2: `sd_o` changes only in the system cycle that follows a detected falling edge of the serial clock. It never changes near a rising edge.
- R3: The receiver samples `sd_i` once per rising serial edge while `rx_en` is 1. The first bit sampled becomes bit 0 of `m_rx_data`.
- R4: After the eighth bit of a character, `sd_o` keeps the value of bit 7 until the next character loads. After reset, `sd_o` is 1.
- R5: When `clk_ext_sel` is 0, `sck_oe` is 1. `sck_o` idles high and gives exactly 8 pulses per character. The low half and the high half of each pulse each last `div_n + 1` system cycles.
- R6: When `clk_ext_sel` is 1, `sck_oe` is 0 and `sck_o` stays 1. Transfers are then timed only by edges on `sck_i`, which must be at most one sixth of the system clock rate.
- R7: With both `tx_en` and `rx_en` at 1, one character is sent and another is received during the same 8 clock pulses.
- R8: `s_tx_ready` is 1 exactly when the holding buffer is empty. A handshake fills the buffer, and the buffer empties at the first falling edge of its character. If a next byte is waiting at the end of a character, it starts with no extra idle time: the high time after the 8th rising edge is `div_n + 1` cycles.
- R9: Once `m_rx_valid` is 1, it and `m_rx_data` hold until a cycle with `m_rx_ready` at 1.
- R10: If a character completes while `m_rx_valid` is 1 and `m_rx_ready` is 0, the following happens. `overrun` goes to 1. The new byte is dropped and the buffered byte is kept. Further reception is ignored until a cycle with `ovr_clear` at 1.
- R11: With the internal clock, `tx_en` at 0 and `rx_en` at 1, the clock runs character after character with no gap. It stops at the end of the character in which `overrun` is set. It also stops at the end of the character in progress when `rx_en` is cleared.
- R12: `tx_end` is 1 after reset. It goes to 0 on a transmit handshake. It goes to 1 at the 8th rising edge of a character when no next byte is waiting.
- R13: After reset, the outputs are: `sck_o`=1, `s_tx_ready`=1, `m_rx_valid`=0, `overrun`=0, `tx_end`=1 and `sd_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmit enable; with the internal clock, a waiting byte starts the clock |
| rx_en | input | 1 | Receive enable |
| clk_ext_sel | input | 1 | 1 = external serial clock on `sck_i`, 0 = internal divider |
| div_n | input | DIV_W | Half period of the internal clock, minus one, in system cycles |
| s_tx_valid | input | 1 | Transmit byte offered |
| s_tx_ready | output | 1 | Transmit holding buffer empty |
| s_tx_data | input | 8 | Transmit byte |
| m_rx_valid | output | 1 | Received byte waiting |
| m_rx_ready | input | 1 | Host takes the received byte |
| m_rx_data | output | 8 | Received byte |
| ovr_clear | input | 1 | Clears the overrun flag |
| tx_end | output | 1 | Transmitter idle, with no byte waiting |
| overrun | output | 1 | Overrun flag |
| sck_i | input | 1 | Clock pin input value |
| sck_o | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin output enable |
| sd_o | output | 1 | Serial data out |
| sd_i | input | 1 | Serial data in |

## Verification
Several rules are checked on every cycle:
- `sd_o` moves only right after a falling-edge strobe.
- Each internal low half lasts `div_n + 1` cycles.
- With the external source selected, the pin output stays high.
- A transmit handshake closes `s_tx_ready`.
- An unaccepted receive byte stays stable.
- The overrun flag stays set, and at the moment it rises the buffered byte is left untouched.

Only the bench scenarios can show the following:
- Bit order and content in both directions.
- The count of eight pulses and the gap-free run of back-to-back characters.
- The held MSB level.
- The clock continuing in receive-only mode and stopping at a character boundary after overrun or disable.
- Transfers timed by an external clock.

// File: rtl/sxcvr_pkg.sv
package sxcvr_pkg;
  localparam int CHAR_BITS = 8;
  localparam int BIT_W = $clog2(CHAR_BITS);
  typedef logic [CHAR_BITS-1:0] char_t;
  typedef struct packed {
    logic fall;
    logic rise;
  } sck_evt_t;
endpackage

// File: rtl/sxcvr_clkgen.sv
module sxcvr_clkgen
  import sxcvr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic [DIV_W-1:0] div_n,
  input  logic             go,
  input  logic             sck_i,
  output logic             sck_o,
  output sck_evt_t         evt
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAR_BITS - 1);

  logic [1:0]       sync_q;
  logic             prev_q;
  logic             ext_fall, ext_rise;
  logic [DIV_W-1:0] half_cnt;
  logic [BIT_W-1:0] pulse_idx;
  logic             active;
  logic             sck_q;
  sck_evt_t         evt_q;

  // two-flop synchronizer and edge detector for the external clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], sck_i};
      prev_q <= sync_q[1];
    end
  end

  assign ext_fall = prev_q & ~sync_q[1];
  assign ext_rise = ~prev_q & sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b1;
      active    <= 1'b0;
      half_cnt  <= '0;
      pulse_idx <= '0;
      evt_q     <= '0;
    end else begin
      evt_q <= '0;
      if (ext_sel) begin
        sck_q      <= 1'b1;
        active     <= 1'b0;
        half_cnt   <= '0;
        pulse_idx  <= '0;
        evt_q.fall <= ext_fall;
        evt_q.rise <= ext_rise;
      end else if (!active) begin
        half_cnt <= '0;
        if (go) begin
          sck_q      <= 1'b0;
          active     <= 1'b1;
          pulse_idx  <= '0;
          evt_q.fall <= 1'b1;
        end
      end else if (half_cnt != div_n) begin
        half_cnt <= half_cnt + 1'b1;
      end else begin
        half_cnt <= '0;
        if (!sck_q) begin
          sck_q      <= 1'b1;
          evt_q.rise <= 1'b1;
        end else if (pulse_idx == LAST_BIT) begin
          if (go) begin
            sck_q      <= 1'b0;
            pulse_idx  <= '0;
            evt_q.fall <= 1'b1;
          end else begin
            active <= 1'b0;
          end
        end else begin
          sck_q      <= 1'b0;
          pulse_idx  <= pulse_idx + 1'b1;
          evt_q.fall <= 1'b1;
        end
      end
    end
  end

  assign sck_o = sck_q;
  assign evt   = evt_q;
endmodule

// File: rtl/sxcvr_tx.sv
module sxcvr_tx
  import sxcvr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tx_en,
  input  sck_evt_t evt,
  input  logic     s_tx_valid,
  output logic     s_tx_ready,
  input  char_t    s_tx_data,
  output logic     sd_o,
  output logic     tx_end,
  output logic     pending
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAR_BITS - 1);

  char_t            hold_q;
  logic             hold_full;
  char_t            shreg;
  logic             busy;
  logic [BIT_W-1:0] bit_idx;
  logic             sd_q;
  logic             end_q;
  logic             push, load;

  assign push = s_tx_valid && !hold_full;
  assign load = evt.fall && !busy && hold_full && tx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      shreg     <= '0;
      busy      <= 1'b0;
      bit_idx   <= '0;
      sd_q      <= 1'b1;
      end_q     <= 1'b1;
    end else begin
      if (push) begin
        hold_q    <= s_tx_data;
        hold_full <= 1'b1;
      end else if (load) begin
        hold_full <= 1'b0;
      end

      if (load) begin
        sd_q    <= hold_q[0];
        shreg   <= hold_q >> 1;
        busy    <= 1'b1;
        bit_idx <= '0;
      end else if (evt.fall && busy) begin
        sd_q  <= shreg[0];
        shreg <= shreg >> 1;
      end

      if (evt.rise && busy) begin
        bit_idx <= bit_idx + 1'b1;
        if (bit_idx == LAST_BIT) busy <= 1'b0;
      end

      if (push) end_q <= 1'b0;
      else if (evt.rise && busy && bit_idx == LAST_BIT && !hold_full) end_q <= 1'b1;
    end
  end

  assign s_tx_ready = !hold_full;
  assign sd_o       = sd_q;
  assign tx_end     = end_q;
  assign pending    = hold_full;
endmodule

// File: rtl/sxcvr_rx.sv
module sxcvr_rx
  import sxcvr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_en,
  input  sck_evt_t evt,
  input  logic     sd_i,
  output logic     m_rx_valid,
  input  logic     m_rx_ready,
  output char_t    m_rx_data,
  input  logic     ovr_clear,
  output logic     overrun
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAR_BITS - 1);

  char_t            shreg;
  char_t            word;
  logic [BIT_W-1:0] bit_idx;
  char_t            buf_q;
  logic             full_q;
  logic             ovr_q;
  logic             pop, sample, done;

  assign pop    = full_q && m_rx_ready;
  assign sample = evt.rise && rx_en && !ovr_q;
  assign done   = sample && (bit_idx == LAST_BIT);
  assign word   = {sd_i, shreg[CHAR_BITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_idx <= '0;
      buf_q   <= '0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (!rx_en) begin
        bit_idx <= '0;
      end else if (sample) begin
        shreg   <= word;
        bit_idx <= bit_idx + 1'b1;
      end

      if (done && (!full_q || pop)) begin
        buf_q  <= word;
        full_q <= 1'b1;
      end else if (pop) begin
        full_q <= 1'b0;
      end

      if (done && full_q && !pop) ovr_q <= 1'b1;
      else if (ovr_clear) ovr_q <= 1'b0;
    end
  end

  assign m_rx_valid = full_q;
  assign m_rx_data  = buf_q;
  assign overrun    = ovr_q;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import sxcvr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             clk_ext_sel,
  input  logic [DIV_W-1:0] div_n,
  input  logic             s_tx_valid,
  output logic             s_tx_ready,
  input  logic [7:0]       s_tx_data,
  output logic             m_rx_valid,
  input  logic             m_rx_ready,
  output logic [7:0]       m_rx_data,
  input  logic             ovr_clear,
  output logic             tx_end,
  output logic             overrun,
  input  logic             sck_i,
  output logic             sck_o,
  output logic             sck_oe,
  output logic             sd_o,
  input  logic             sd_i
);
  sck_evt_t sck_evt;
  logic     tx_pending;
  logic     go;
  logic     evt_fall;

  // a waiting byte drives the clock when transmitting; otherwise receive-only runs freely
  assign go       = tx_en ? tx_pending : (rx_en && !overrun);
  assign sck_oe   = ~clk_ext_sel;
  assign evt_fall = sck_evt.fall;

  sxcvr_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_sel (clk_ext_sel),
    .div_n   (div_n),
    .go      (go),
    .sck_i   (sck_i),
    .sck_o   (sck_o),
    .evt     (sck_evt)
  );

  sxcvr_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .evt        (sck_evt),
    .s_tx_valid (s_tx_valid),
    .s_tx_ready (s_tx_ready),
    .s_tx_data  (s_tx_data),
    .sd_o       (sd_o),
    .tx_end     (tx_end),
    .pending    (tx_pending)
  );

  sxcvr_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .evt        (sck_evt),
    .sd_i       (sd_i),
    .m_rx_valid (m_rx_valid),
    .m_rx_ready (m_rx_ready),
    .m_rx_data  (m_rx_data),
    .ovr_clear  (ovr_clear),
    .overrun    (overrun)
  );
endmodule

// File: rtl/sxcvr_checker.sv
module sxcvr_checker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_ext_sel,
  input logic [DIV_W-1:0] div_n,
  input logic             sck_o,
  input logic             sd_o,
  input logic             evt_fall,
  input logic             s_tx_valid,
  input logic             s_tx_ready,
  input logic             m_rx_valid,
  input logic             m_rx_ready,
  input logic [7:0]       m_rx_data,
  input logic             overrun,
  input logic             ovr_clear
);
  logic [DIV_W:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!sck_o) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  AST_SD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_o) |-> $past(evt_fall)); // R2

  AST_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sck_o) && !clk_ext_sel) |-> (low_cnt == ({1'b0, div_n} + (DIV_W+1)'(1)))); // R5

  AST_EXT_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ext_sel |=> sck_o); // R6

  AST_TX_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tx_valid && s_tx_ready) |=> !s_tx_ready); // R8

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rx_valid && !m_rx_ready) |=> (m_rx_valid && $stable(m_rx_data))); // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clear) |=> overrun); // R10

  AST_OVR_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> (m_rx_valid && $stable(m_rx_data))); // R10
endmodule

bind sync_serial_xcvr sxcvr_checker #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_ext_sel (clk_ext_sel),
  .div_n       (div_n),
  .sck_o       (sck_o),
  .sd_o        (sd_o),
  .evt_fall    (evt_fall),
  .s_tx_valid  (s_tx_valid),
  .s_tx_ready  (s_tx_ready),
  .m_rx_valid  (m_rx_valid),
  .m_rx_ready  (m_rx_ready),
  .m_rx_data   (m_rx_data),
  .overrun     (overrun),
  .ovr_clear   (ovr_clear)
);

// File: tb/sync_serial_xcvr_bench.sv
`timescale 1ns/1ps
module sync_serial_xcvr_bench;
  localparam int DIV_W = 8;
  localparam int NVEC = 6;
  // [23:16] divider, [15:8] byte to send, [7:0] byte the partner sends
  localparam logic [23:0] VEC [NVEC] = '{
    24'h01_A5_3C, 24'h02_01_80, 24'h03_FF_00,
    24'h01_80_7E, 24'h05_5A_C3, 24'h04_00_FF
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0, clk_ext_sel = 1'b0;
  logic [DIV_W-1:0] div_n = 8'd1;
  logic s_tx_valid = 1'b0;
  logic [7:0] s_tx_data = '0;
  logic s_tx_ready, m_rx_valid, tx_end, overrun, sck_o, sck_oe, sd_o;
  logic m_rx_ready = 1'b0, ovr_clear = 1'b0;
  logic [7:0] m_rx_data;
  logic sd_i = 1'b1;
  logic ext_clk = 1'b1;
  logic sck_line;

  int checks = 0, failures = 0;
  int rise_cnt = 0, fall_cnt = 0;
  time t_rise = 0;
  int max_gap = 0;
  logic [15:0] p_out = '0, p_in = '0;

  always #5 clk = ~clk;

  assign sck_line = (sck_oe === 1'b1) ? sck_o : ext_clk;

  sync_serial_xcvr #(.DIV_W(DIV_W)) u_sync_serial_xcvr (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .clk_ext_sel(clk_ext_sel), .div_n(div_n),
    .s_tx_valid(s_tx_valid), .s_tx_ready(s_tx_ready), .s_tx_data(s_tx_data),
    .m_rx_valid(m_rx_valid), .m_rx_ready(m_rx_ready), .m_rx_data(m_rx_data),
    .ovr_clear(ovr_clear), .tx_end(tx_end), .overrun(overrun),
    .sck_i(sck_line), .sck_o(sck_o), .sck_oe(sck_oe), .sd_o(sd_o), .sd_i(sd_i)
  );

  // serial partner: drives after falling edges, samples after rising edges
  always @(negedge sck_line) begin
    #1;
    sd_i = p_out[0];
    p_out = p_out >> 1;
    fall_cnt++;
    if (rise_cnt > 0 && int'(($time - t_rise) / 10) > max_gap)
      max_gap = int'(($time - t_rise) / 10);
  end

  always @(posedge sck_line) begin
    #1;
    p_in = {sd_o, p_in[15:1]};
    rise_cnt++;
    t_rise = $time;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_partner();
    rise_cnt = 0; fall_cnt = 0; max_gap = 0; p_in = '0;
  endtask

  task automatic send(input logic [7:0] b);
    int guard = 0;
    @(negedge clk);
    while (!s_tx_ready && guard < 5000) begin @(negedge clk); guard++; end
    s_tx_valid = 1'b1; s_tx_data = b;
    @(negedge clk);
    s_tx_valid = 1'b0;
  endtask

  task automatic take();
    @(negedge clk); m_rx_ready = 1'b1;
    @(negedge clk); m_rx_ready = 1'b0;
  endtask

  task automatic wait_tx_end();
    int guard = 0;
    while (!tx_end && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    // R13 reset state
    chk(sck_o == 1'b1, "R13 sck_o", sck_o, 1);
    chk(s_tx_ready == 1'b1, "R13 s_tx_ready", s_tx_ready, 1);
    chk(m_rx_valid == 1'b0, "R13 m_rx_valid", m_rx_valid, 0);
    chk(overrun == 1'b0, "R13 overrun", overrun, 0);
    chk(tx_end == 1'b1, "R12 tx_end at reset", tx_end, 1);
    chk(sd_o == 1'b1, "R4 sd_o at reset", sd_o, 1);
    rst_n = 1'b1;
    cyc(3);
    chk(sck_oe == 1'b1, "R5 sck_oe internal", sck_oe, 1);

    // table walk: full-duplex exchange with internal clock
    for (int v = 0; v < NVEC; v++) begin
      div_n = VEC[v][23:16];
      tx_en = 1'b1; rx_en = 1'b1;
      clr_partner();
      p_out = {8'h00, VEC[v][7:0]};
      send(VEC[v][15:8]);
      wait_tx_end();
      cyc(2 * (int'(div_n) + 1) + 6);
      chk(p_in[15:8] == VEC[v][15:8], "R1 sent byte", p_in[15:8], VEC[v][15:8]);
      chk(m_rx_valid && m_rx_data == VEC[v][7:0], "R3 R7 received byte", m_rx_data, VEC[v][7:0]);
      chk(rise_cnt == 8, "R5 pulse count", rise_cnt, 8);
      chk(max_gap == int'(div_n) + 1, "R5 high half", max_gap, int'(div_n) + 1);
      chk(sd_o == VEC[v][15], "R4 holds MSB", sd_o, VEC[v][15]);
      chk(sck_o == 1'b1, "R5 idle high", sck_o, 1);
      take();
    end

    // back-to-back characters, transmit only
    div_n = 8'd2; rx_en = 1'b0; tx_en = 1'b1;
    clr_partner();
    send(8'h3C);
    chk(tx_end == 1'b0, "R12 cleared on accept", tx_end, 0);
    send(8'hC3);
    wait_tx_end();
    cyc(12);
    chk(rise_cnt == 16, "R8 two chars pulses", rise_cnt, 16);
    chk(max_gap == 3, "R8 no gap between chars", max_gap, 3);
    chk(p_in == 16'hC33C, "R1 R8 two chars", p_in, 16'hC33C);
    chk(sd_o == 1'b1, "R4 MSB of C3", sd_o, 1);
    chk(tx_end == 1'b1, "R12 set at end", tx_end, 1);

    // receive-only free-running clock until overrun
    tx_en = 1'b0; div_n = 8'd1;
    clr_partner();
    p_out = 16'h9669;
    rx_en = 1'b1;
    cyc(120);
    chk(overrun == 1'b1, "R10 overrun flagged", overrun, 1);
    chk(m_rx_valid && m_rx_data == 8'h69, "R10 first byte kept", m_rx_data, 8'h69);
    chk(rise_cnt == 16, "R11 stops after overrun char", rise_cnt, 16);
    cyc(60);
    chk(rise_cnt == 16 && sck_o == 1'b1, "R11 clock stays stopped", rise_cnt, 16);

    // clear with receive disabled: no clock, flag gone
    rx_en = 1'b0;
    @(negedge clk); ovr_clear = 1'b1;
    @(negedge clk); ovr_clear = 1'b0;
    take();
    cyc(40);
    chk(overrun == 1'b0, "R10 cleared", overrun, 0);
    chk(rise_cnt == 16, "R11 no clock with rx off", rise_cnt, 16);

    // receive-only: disable mid second char, clock finishes that char
    clr_partner();
    p_out = 16'h00E1;
    rx_en = 1'b1;
    begin
      int guard = 0;
      while (rise_cnt < 12 && guard < 2000) begin @(negedge clk); guard++; end
    end
    rx_en = 1'b0;
    cyc(40);
    chk(rise_cnt == 16, "R11 finishes char on disable", rise_cnt, 16);
    chk(m_rx_valid && m_rx_data == 8'hE1, "R3 receive-only byte", m_rx_data, 8'hE1);
    chk(overrun == 1'b0, "R10 no overrun when disabled", overrun, 0);
    take();

    // external clock exchange
    clk_ext_sel = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
    cyc(4);
    clr_partner();
    p_out = {8'h00, 8'h4B};
    send(8'hD2);
    cyc(30);
    chk(sck_oe == 1'b0, "R6 pin released", sck_oe, 0);
    chk(rise_cnt == 0 && s_tx_ready == 1'b0, "R6 waits for external clock", rise_cnt, 0);
    chk(sck_o == 1'b1, "R6 sck_o high", sck_o, 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); ext_clk = 1'b0; cyc(6);
      ext_clk = 1'b1; cyc(6);
    end
    cyc(10);
    chk(p_in[15:8] == 8'hD2, "R6 R1 sent byte ext", p_in[15:8], 8'hD2);
    chk(m_rx_valid && m_rx_data == 8'h4B, "R6 R7 received byte ext", m_rx_data, 8'h4B);
    chk(tx_end == 1'b1, "R12 end ext", tx_end, 1);
    chk(sd_o == 1'b1, "R4 MSB ext", sd_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule